// File: doc/BRIEF.md
# Byte-Lane System Register Bank

This block holds six CPU system registers on a 16-bit register bus that carries both word and byte writes. A request selects one register with address bits 4:1. Address bit 0 marks the odd (upper) byte of a byte access. Byte write data always travels in the low 8 bits of the write bus, and each register places or discards that byte according to its own lane policy.

The bank contains six registers:
- A software interrupt request word.
- A stack limit word that keeps only its upper byte.
- A memory error word whose bits are set by hardware and cleared by writing ones.
- A control/display word that keeps only its low byte.
- Two plain scratch words that merge byte writes into the addressed byte.

Every request gets a registered response one cycle later: either an acknowledge, or an error for an unmapped select.

Top module: `sysreg_lane_bank`

## Requirements
- R1: The select is `req_addr[4:1]`. Selects 0 to 5 map to the interrupt request, stack limit, memory error, control/display, scratch A and scratch B registers. Any other select returns `rsp_err`=1 and `rsp_ack`=0 one cycle later, and no register changes.
- R2: A mapped request gets `rsp_ack`=1 in the cycle after it is sampled. For a read, `rsp_rdata` holds the register word as it stood before that edge. For a write, `rsp_rdata` is 0. With no request, both `rsp_ack` and `rsp_err` are 0.
- R3: Interrupt request (select 0): a word write loads all 16 bits. An even byte write is ignored. An odd byte write loads `req_wdata[7:0]` into bits 15:8 and zeros bits 7:0.
- R4: Stack limit (select 1): the writable mask is 0xFF00, and bits 7:0 always read 0. Word writes load data AND 0xFF00. Even byte writes are ignored. Odd byte writes load `req_wdata[7:0]` into bits 15:8.
- R5: Memory error (select 2): a word write clears every bit where the data is 1. An odd byte write clears bits 15:8 wherever `req_wdata[7:0]` is 1. An even byte write clears bits 7:0 in the same way. `err_set` sets bits every cycle, and a set wins over a clear of the same bit in the same cycle.
- R6: Control/display (select 3): the writable mask is 0x00FF, and bits 15:8 always read 0. Odd byte writes are ignored. Even byte writes and word writes load the low byte.
- R7: Scratch A and B (selects 4 and 5): word writes load 16 bits. A byte write changes only the addressed byte and leaves the other byte unchanged.
- R8: After reset every register reads 0 and all response outputs are 0.
- R9: Reads have no side effects: repeated reads return the same word.
- R10: For byte writes, `req_wdata[15:8]` is ignored. For word writes, `req_addr[0]` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte write, 0 = word access |
| req_addr | input | 5 | Bits 4:1 select the register, bit 0 selects the odd byte |
| req_wdata | input | 16 | Write data; byte data in bits 7:0 |
| err_set | input | 16 | Hardware set pulses for the memory error register |
| rsp_ack | output | 1 | Registered acknowledge |
| rsp_err | output | 1 | Registered nonexistent-register error |
| rsp_rdata | output | 16 | Registered read data |

## Verification
A lane routed to the wrong half, or a write that should have been dropped, leaves a stale or shifted word in the register. This shows on the next read of that register, exactly two cycles after the faulty write is sampled. The bench therefore reads back each register after every write, with upper garbage on the byte data, so that a byte taken from the wrong bits is visible.

A clear/set priority error in the memory error register shows in the readback that follows the cycle where both are applied. A decode fault shows one cycle after the request, as a swapped acknowledge and error. It also shows as a changed neighbouring register on its next read.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int NUM_SLOTS = 6;

  localparam int SLOT_IRQ  = 0;
  localparam int SLOT_STK  = 1;
  localparam int SLOT_MERR = 2;
  localparam int SLOT_CTRL = 3;

  typedef enum logic [1:0] {
    LANE_SHIFT_ODD, // even byte dropped, odd byte lands high with low zeroed
    LANE_LOW_ONLY,  // odd byte dropped, even byte lands low
    LANE_PLACE,     // byte lands in its own half, other half zero
    LANE_MERGE      // byte lands in its own half, other half kept
  } lane_pol_e;

  function automatic lane_pol_e slot_policy(int idx);
    case (idx)
      SLOT_IRQ, SLOT_STK: return LANE_SHIFT_ODD;
      SLOT_MERR:          return LANE_PLACE;
      SLOT_CTRL:          return LANE_LOW_ONLY;
      default:            return LANE_MERGE;
    endcase
  endfunction

  function automatic logic [63:0] slot_mask(int idx, int w);
    logic [63:0] all_ones;
    logic [63:0] low_half;
    all_ones = (64'd1 << w) - 64'd1;
    low_half = (64'd1 << (w / 2)) - 64'd1;
    case (idx)
      SLOT_STK:  return all_ones ^ low_half;
      SLOT_CTRL: return low_half;
      default:   return all_ones;
    endcase
  endfunction

  function automatic bit slot_clears(int idx);
    return idx == SLOT_MERR;
  endfunction

endpackage

// File: rtl/lane_policy.sv
module lane_policy
  import sysreg_pkg::*;
#(
  parameter int          DATA_W = 16,
  parameter lane_pol_e   POLICY = LANE_MERGE,
  parameter logic [DATA_W-1:0] WMASK = '1,
  parameter bit          CLEAR_MODE = 1'b0
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  input  logic              byte_acc,
  input  logic              odd_acc,
  output logic              take,
  output logic [DATA_W-1:0] nxt
);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0]   lo_byte;
  logic [DATA_W-1:0] image;

  assign lo_byte = wdata[HALF-1:0];

  always_comb begin
    take  = 1'b1;
    image = wdata;
    if (byte_acc) begin
      case (POLICY)
        LANE_SHIFT_ODD: begin
          take  = odd_acc;
          image = {lo_byte, {HALF{1'b0}}};
        end
        LANE_LOW_ONLY: begin
          take  = !odd_acc;
          image = {{HALF{1'b0}}, lo_byte};
        end
        LANE_PLACE: begin
          image = odd_acc ? {lo_byte, {HALF{1'b0}}} : {{HALF{1'b0}}, lo_byte};
        end
        default: begin
          image = odd_acc ? {lo_byte, cur[HALF-1:0]} : {cur[DATA_W-1:HALF], lo_byte};
        end
      endcase
    end
  end

  generate
    if (CLEAR_MODE) begin : g_clear
      assign nxt = cur & ~(image & WMASK);
    end else begin : g_load
      assign nxt = image & WMASK;
    end
  endgenerate

endmodule

// File: rtl/reg_slot.sv
module reg_slot
  import sysreg_pkg::*;
#(
  parameter int          DATA_W = 16,
  parameter lane_pol_e   POLICY = LANE_MERGE,
  parameter logic [DATA_W-1:0] WMASK = '1,
  parameter bit          CLEAR_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              byte_acc,
  input  logic              odd_acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] set_bits,
  output logic [DATA_W-1:0] q
);
  logic              take;
  logic [DATA_W-1:0] nxt;

  lane_policy #(
    .DATA_W(DATA_W), .POLICY(POLICY), .WMASK(WMASK), .CLEAR_MODE(CLEAR_MODE)
  ) u_pol (
    .cur(q), .wdata(wdata), .byte_acc(byte_acc), .odd_acc(odd_acc),
    .take(take), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ((hit && take) ? nxt : q) | set_bits;
  end

  // set bits are visible on the next cycle regardless of any write (R5)
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & $past(set_bits)) == $past(set_bits)));

endmodule

// File: rtl/sysreg_lane_bank.sv
module sysreg_lane_bank
  import sysreg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] err_set,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int SEL_W = ADDR_W - 1;
  localparam int HALF  = DATA_W / 2;

  logic [SEL_W-1:0]  sel;
  logic              odd_acc;
  logic              byte_wr;
  logic              mapped;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] slot_q [NUM_SLOTS];

  assign sel     = req_addr[ADDR_W-1:1];
  assign odd_acc = req_addr[0];
  assign byte_wr = req_write && req_byte;

  generate
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      localparam lane_pol_e         POL  = slot_policy(i);
      localparam logic [63:0]       MSK  = slot_mask(i, DATA_W);
      localparam bit                CLR  = slot_clears(i);
      logic              hit;
      logic [DATA_W-1:0] set_bits;

      assign hit      = req_valid && req_write && (sel == SEL_W'(i));
      assign set_bits = CLR ? err_set : '0;

      reg_slot #(
        .DATA_W(DATA_W), .POLICY(POL), .WMASK(MSK[DATA_W-1:0]), .CLEAR_MODE(CLR)
      ) u_reg (
        .clk(clk), .rst(rst), .hit(hit), .byte_acc(byte_wr), .odd_acc(odd_acc),
        .wdata(req_wdata), .set_bits(set_bits), .q(slot_q[i])
      );
    end
  endgenerate

  always_comb begin
    mapped  = 1'b0;
    rd_word = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (sel == SEL_W'(i)) begin
        mapped  = 1'b1;
        rd_word = slot_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ack   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ack   <= req_valid && mapped;
      rsp_err   <= req_valid && !mapped;
      rsp_rdata <= (req_valid && mapped && !req_write) ? rd_word : '0;
    end
  end

  p_resp_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    !(rsp_ack && rsp_err));

  p_unmapped_err_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (sel >= SEL_W'(NUM_SLOTS))) |=> (rsp_err && !rsp_ack));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_ack && !rsp_err));

  p_stk_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && (sel == SEL_W'(SLOT_STK)))
      |=> (rsp_rdata[HALF-1:0] == '0));

  p_ctrl_high_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && (sel == SEL_W'(SLOT_CTRL)))
      |=> (rsp_rdata[DATA_W-1:HALF] == '0));

endmodule

// File: tb/sysreg_lane_bank_tb.sv
module sysreg_lane_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_byte  = 1'b0;
  logic [4:0]  req_addr  = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] err_set   = '0;
  logic        rsp_ack;
  logic        rsp_err;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sysreg_lane_bank dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .err_set(err_set), .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request; responses sampled on the following negedge
  task automatic xfer(input bit wr, input bit bt, input int sel, input bit odd,
                      input logic [15:0] d, output logic a, output logic e,
                      output logic [15:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = bt;
    req_addr = {sel[3:0], odd}; req_wdata = d;
    @(negedge clk);
    a = rsp_ack; e = rsp_err; r = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic wr(string req, int sel, bit bt, bit odd, logic [15:0] d);
    logic a, e; logic [15:0] r;
    xfer(1'b1, bt, sel, odd, d, a, e, r);
    check({req, " write ack"}, {a, e, r}, {1'b1, 1'b0, 16'h0});
  endtask

  task automatic rd_check(string req, int sel, logic [15:0] exp);
    logic a, e; logic [15:0] r;
    xfer(1'b0, 1'b0, sel, 1'b0, 16'h0, a, e, r);
    check({req, " readback"}, {a, e, r}, {1'b1, 1'b0, exp});
  endtask

  task automatic t_reset;
    check("R8 reset outputs", {rsp_ack, rsp_err, rsp_rdata}, 18'h0);
    for (int i = 0; i < 6; i++) rd_check("R8 reset value", i, 16'h0);
    @(negedge clk);
    check("R2 idle no response", {rsp_ack, rsp_err}, 2'b00);
  endtask

  task automatic t_irq;
    wr("R3", 0, 1'b0, 1'b1, 16'h1234);
    rd_check("R3 word load odd addr R10", 0, 16'h1234);
    wr("R3", 0, 1'b1, 1'b0, 16'hFF56);
    rd_check("R3 even byte ignored", 0, 16'h1234);
    wr("R3", 0, 1'b1, 1'b1, 16'hFFA5);
    rd_check("R3 odd byte shift R10", 0, 16'hA500);
  endtask

  task automatic t_stk;
    wr("R4", 1, 1'b0, 1'b0, 16'h1234);
    rd_check("R4 word masked", 1, 16'h1200);
    wr("R4", 1, 1'b1, 1'b0, 16'h0077);
    rd_check("R4 even byte ignored", 1, 16'h1200);
    wr("R4", 1, 1'b1, 1'b1, 16'hC33C);
    rd_check("R4 odd byte shift", 1, 16'h3C00);
  endtask

  task automatic t_merr;
    @(negedge clk); err_set = 16'hFFFF;
    @(negedge clk); err_set = 16'h0000;
    rd_check("R5 set all", 2, 16'hFFFF);
    wr("R5", 2, 1'b0, 1'b0, 16'h000F);
    rd_check("R5 word clear", 2, 16'hFFF0);
    wr("R5", 2, 1'b1, 1'b1, 16'h0081);
    rd_check("R5 odd byte clear", 2, 16'h7EF0);
    wr("R5", 2, 1'b1, 1'b0, 16'hFF30);
    rd_check("R5 even byte clear", 2, 16'h7EC0);
    begin
      logic a, e; logic [15:0] r;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_byte = 1'b0;
      req_addr = {4'd2, 1'b0}; req_wdata = 16'h4001; err_set = 16'h0001;
      @(negedge clk);
      a = rsp_ack; req_valid = 1'b0; err_set = 16'h0;
      check("R5 set/clear ack", {31'h0, a}, 32'h1);
    end
    rd_check("R5 set wins over clear", 2, 16'h3EC1);
    rd_check("R9 repeat read", 2, 16'h3EC1);
  endtask

  task automatic t_ctrl;
    wr("R6", 3, 1'b0, 1'b0, 16'hABCD);
    rd_check("R6 word masked", 3, 16'h00CD);
    wr("R6", 3, 1'b1, 1'b1, 16'h0011);
    rd_check("R6 odd byte ignored", 3, 16'h00CD);
    wr("R6", 3, 1'b1, 1'b0, 16'hEE42);
    rd_check("R6 even byte load", 3, 16'h0042);
  endtask

  task automatic t_merge;
    wr("R7", 4, 1'b0, 1'b0, 16'h1234);
    wr("R7", 5, 1'b0, 1'b0, 16'hFFFF);
    wr("R7", 4, 1'b1, 1'b0, 16'h99AB);
    rd_check("R7 even merge", 4, 16'h12AB);
    wr("R7", 4, 1'b1, 1'b1, 16'h77CD);
    rd_check("R7 odd merge", 4, 16'hCDAB);
    rd_check("R7 neighbour untouched", 5, 16'hFFFF);
    wr("R7", 5, 1'b1, 1'b1, 16'h5500);
    rd_check("R7 odd zero byte", 5, 16'h00FF);
  endtask

  task automatic t_unmapped;
    logic a, e; logic [15:0] r;
    xfer(1'b1, 1'b0, 6, 1'b0, 16'hDEAD, a, e, r);
    check("R1 unmapped write err", {a, e}, 2'b01);
    xfer(1'b0, 1'b0, 15, 1'b0, 16'h0, a, e, r);
    check("R1 unmapped read err", {a, e, r}, {1'b0, 1'b1, 16'h0});
    for (int i = 0; i < 6; i++) begin
      logic [15:0] exp [6] = '{16'hA500, 16'h3C00, 16'h3EC1, 16'h0042, 16'hCDAB, 16'h00FF};
      rd_check("R1 no state change", i, exp[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_irq();
    t_stk();
    t_merr();
    t_ctrl();
    t_merge();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule